// File: doc/BRIEF.md
# Four-Channel KCS Mailbox Controller

This block holds four independent keyboard-controller-style mailbox channels shared by a management processor and a host. Each channel has three registers: an input data register that the host fills, an output data register that the management processor fills, and a status register. The status register carries two handshake flags, one for each direction, plus a command/data indicator. The management processor reaches every register through a word-addressed 32-bit register port that spans 4 KB. The host has a separate port for each channel. Through it the host writes input data, reads output data and watches the status.

Each handshake flag is set by the side that fills a buffer and cleared by the side that drains it. When both happen for the same flag in the same cycle, the set wins. Each channel has an interrupt that tells the management processor new input has arrived. It fires only when the channel is enabled and its interrupt enable is on. The four channel lines and one auxiliary source are latched into a pending vector, and the aggregated interrupt output is the OR of that vector.

Top module: `kcs_mbox`

## Requirements
- R1: Reset clears every register, every flag, every channel interrupt and the pending vector to zero. The one exception is the control register at byte offset 0x88, which loads the value of the parameter `STRAP7`.
- R2: The word index on `m_addr` is the byte offset shifted right by two. Plain 32-bit control registers sit at 0x00, 0x04, 0x08, 0x0C, 0x10, 0x80, 0x84, 0x88, 0x8C and 0x100. For channels 1, 2, 3 and 4 in that order, the status registers sit at 0x3C/0x40/0x44/0x11C, the input data registers at 0x24/0x28/0x2C/0x114, and the output data registers at 0x30/0x34/0x38/0x118. A management read returns the addressed register combinationally, and a management write stores all 32 bits at the clock edge.
- R3: Each channel's enable comes from these bits. Channel 1 uses bit 5 of 0x00 and channel 2 uses bit 6 of 0x00. Channel 3 needs both bit 7 of 0x00 and bit 2 of 0x10. Channel 4 uses bit 0 of 0x100. The interrupt enables are bits 1, 2 and 3 of 0x08 for channels 1 to 3, and bit 1 of 0x100 for channel 4. A channel interrupt rises only when both its enable and its interrupt enable are set.
- R4: A host write to a channel's input data loads the data and sets status bit 1 (input full) at the next edge. If the channel is armed, the same write raises that channel's interrupt line.
- R5: A management read of a channel's input data register clears status bit 1 at the edge. If bit 1 was set, the read also lowers the channel interrupt.
- R6: A management write to a channel's output data register loads the data and sets status bit 0 (output full). A host read of output data returns the stored data and clears bit 0 at the edge.
- R7: When a set and a clear of the same flag land in the same cycle, the flag ends up set.
- R8: A management write to a status register replaces all of its bits, including bit 3 (command/data). The host port has no way to write status.
- R9: A 5-bit pending vector registers the four channel interrupt lines (bits 0 to 3) and `aux_irq` (bit 4) every cycle. `irq_out` is the OR of that vector, so it follows its sources one cycle later.
- R10: A management access to any word index that holds no register reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | 10 | Management word index (byte offset >> 2) |
| m_wr | input | 1 | Management write strobe |
| m_rd | input | 1 | Management read strobe (side effects) |
| m_wdata | input | 32 | Management write data |
| m_rdata | output | 32 | Management read data |
| h_wr | input | 4 | Host input-data write strobe, one per channel |
| h_wdata | input | 128 | Host write data, 32 bits per channel |
| h_rd | input | 4 | Host output-data read strobe, one per channel |
| h_odr | output | 128 | Output data per channel |
| h_str | output | 128 | Status per channel |
| aux_irq | input | 1 | Additional interrupt source |
| chan_irq | output | 4 | Channel interrupt lines |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The bench aims at collisions: a host write and a management read hitting the same input flag in one cycle, and an output-data write landing together with a host read. A design with the priority reversed would drop a byte from the handshake, and the status then shows empty while data is waiting. The bench also toggles channel 3's second enable bit. A design that checked only one bit would raise that channel's interrupt when it should stay quiet. It also reads input data while the flag is already clear, where a design that lowered the interrupt unconditionally would lose a pending request. Finally it probes reserved and out-of-range offsets, where a design that aliased them would return stale data.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;
  localparam int NCH   = 4;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int NCTL  = 10;
  localparam int NSRC  = NCH + 1;

  typedef logic [AW-1:0] widx_t;

  localparam int OBF_B = 0;
  localparam int IBF_B = 1;

  // control slot numbering (slot 7 holds the strap register)
  localparam int SL_EN   = 0;
  localparam int SL_IE   = 2;
  localparam int SL_EN3  = 4;
  localparam int SL_STRP = 7;
  localparam int SL_X    = 9;

  function automatic widx_t ctl_idx(input int k);
    logic [11:0] b;
    case (k)
      0: b = 12'h000; 1: b = 12'h004; 2: b = 12'h008; 3: b = 12'h00C;
      4: b = 12'h010; 5: b = 12'h080; 6: b = 12'h084; 7: b = 12'h088;
      8: b = 12'h08C; default: b = 12'h100;
    endcase
    return widx_t'(b >> 2);
  endfunction

  function automatic widx_t idr_idx(input int c);
    logic [11:0] b;
    case (c)
      0: b = 12'h024; 1: b = 12'h028; 2: b = 12'h02C; default: b = 12'h114;
    endcase
    return widx_t'(b >> 2);
  endfunction

  function automatic widx_t odr_idx(input int c);
    logic [11:0] b;
    case (c)
      0: b = 12'h030; 1: b = 12'h034; 2: b = 12'h038; default: b = 12'h118;
    endcase
    return widx_t'(b >> 2);
  endfunction

  function automatic widx_t str_idx(input int c);
    logic [11:0] b;
    case (c)
      0: b = 12'h03C; 1: b = 12'h040; 2: b = 12'h044; default: b = 12'h11C;
    endcase
    return widx_t'(b >> 2);
  endfunction

  function automatic logic is_mapped(input widx_t a);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NCTL; k++) if (a == ctl_idx(k)) hit = 1'b1;
    for (int c = 0; c < NCH; c++)
      if (a == idr_idx(c) || a == odr_idx(c) || a == str_idx(c)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/kcs_mbox_ctl.sv
module kcs_mbox_ctl
  import kcs_mbox_pkg::*;
#(
  parameter logic [DW-1:0] STRAP7 = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  widx_t                    m_addr,
  input  logic                     m_wr,
  input  logic [DW-1:0]            m_wdata,
  output logic [NCTL-1:0][DW-1:0]  ctl_q,
  output logic [NCH-1:0]           arm
);
  logic [NCTL-1:0] wen;
  logic [NCH-1:0]  en, ie;

  for (genvar k = 0; k < NCTL; k++) begin : g_slot
    localparam logic [DW-1:0] RSTV = (k == SL_STRP) ? STRAP7 : '0;
    assign wen[k] = m_wr && (m_addr == ctl_idx(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q[k] <= RSTV;
      else if (wen[k]) ctl_q[k] <= m_wdata;
    end
  end

  always_comb begin
    en[0] = ctl_q[SL_EN][5];
    en[1] = ctl_q[SL_EN][6];
    en[2] = ctl_q[SL_EN][7] && ctl_q[SL_EN3][2];
    en[3] = ctl_q[SL_X][0];
    ie[0] = ctl_q[SL_IE][1];
    ie[1] = ctl_q[SL_IE][2];
    ie[2] = ctl_q[SL_IE][3];
    ie[3] = ctl_q[SL_X][1];
    arm   = en & ie;
  end
endmodule

// File: rtl/kcs_mbox_chan.sv
module kcs_mbox_chan
  import kcs_mbox_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          h_wr,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_rd,
  input  logic          m_idr_wr,
  input  logic          m_idr_rd,
  input  logic          m_odr_wr,
  input  logic          m_str_wr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] idr_q,
  output logic [DW-1:0] odr_q,
  output logic [DW-1:0] str_q,
  output logic          irq_q
);
  logic [DW-1:0] idr_d, str_d;
  logic          idr_en, irq_d;

  always_comb begin
    idr_en = h_wr || m_idr_wr;
    idr_d  = h_wr ? h_wdata : m_wdata;
    // base value, then clears, then sets: a set in the same cycle wins
    str_d  = m_str_wr ? m_wdata : str_q;
    if (m_idr_rd) str_d[IBF_B] = 1'b0;
    if (h_rd)     str_d[OBF_B] = 1'b0;
    if (h_wr)     str_d[IBF_B] = 1'b1;
    if (m_odr_wr) str_d[OBF_B] = 1'b1;
    irq_d = irq_q;
    if (m_idr_rd && str_q[IBF_B]) irq_d = 1'b0;
    if (h_wr && arm)              irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr_q <= '0;
      odr_q <= '0;
      str_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (idr_en)   idr_q <= idr_d;
      if (m_odr_wr) odr_q <= m_wdata;
      str_q <= str_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/kcs_mbox_irq.sv
module kcs_mbox_irq #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  output logic            agg
);
  logic [NSRC-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src;
  end

  assign agg = |pend_q;
endmodule

// File: rtl/kcs_mbox.sv
module kcs_mbox
  import kcs_mbox_pkg::*;
#(
  parameter logic [31:0] STRAP7 = 32'h0000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       m_addr,
  input  logic                m_wr,
  input  logic                m_rd,
  input  logic [DW-1:0]       m_wdata,
  output logic [DW-1:0]       m_rdata,
  input  logic [NCH-1:0]      h_wr,
  input  logic [NCH*DW-1:0]   h_wdata,
  input  logic [NCH-1:0]      h_rd,
  output logic [NCH*DW-1:0]   h_odr,
  output logic [NCH*DW-1:0]   h_str,
  input  logic                aux_irq,
  output logic [NCH-1:0]      chan_irq,
  output logic                irq_out
);
  logic [NCTL-1:0][DW-1:0] ctl_q;
  logic [NCH-1:0]          arm;
  logic [NCH-1:0][DW-1:0]  idr_q, odr_q, str_q;

  kcs_mbox_ctl #(.STRAP7(STRAP7)) u_ctl (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr),
    .m_wdata(m_wdata), .ctl_q(ctl_q), .arm(arm)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    kcs_mbox_chan u_chan (
      .clk(clk), .rst_n(rst_n), .arm(arm[c]),
      .h_wr(h_wr[c]), .h_wdata(h_wdata[c*DW +: DW]), .h_rd(h_rd[c]),
      .m_idr_wr(m_wr && m_addr == idr_idx(c)),
      .m_idr_rd(m_rd && m_addr == idr_idx(c)),
      .m_odr_wr(m_wr && m_addr == odr_idx(c)),
      .m_str_wr(m_wr && m_addr == str_idx(c)),
      .m_wdata(m_wdata),
      .idr_q(idr_q[c]), .odr_q(odr_q[c]), .str_q(str_q[c]),
      .irq_q(chan_irq[c])
    );
    assign h_odr[c*DW +: DW] = odr_q[c];
    assign h_str[c*DW +: DW] = str_q[c];
  end

  kcs_mbox_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .src({aux_irq, chan_irq}), .agg(irq_out)
  );

  always_comb begin
    m_rdata = '0;
    for (int k = 0; k < NCTL; k++)
      if (m_addr == ctl_idx(k)) m_rdata = ctl_q[k];
    for (int c = 0; c < NCH; c++) begin
      if (m_addr == idr_idx(c)) m_rdata = idr_q[c];
      if (m_addr == odr_idx(c)) m_rdata = odr_q[c];
      if (m_addr == str_idx(c)) m_rdata = str_q[c];
    end
  end
endmodule

// File: rtl/kcs_mbox_chk.sv
module kcs_mbox_chk
  import kcs_mbox_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       m_addr,
  input logic                m_wr,
  input logic                m_rd,
  input logic [DW-1:0]       m_rdata,
  input logic [NCH-1:0]      h_wr,
  input logic [NCH-1:0]      h_rd,
  input logic [NCH*DW-1:0]   h_str,
  input logic                aux_irq,
  input logic [NCH-1:0]      chan_irq,
  input logic                irq_out,
  input logic [NCH-1:0]      arm
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R4
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_wr[c] |=> h_str[c*DW + IBF_B]);
    // R5
    ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd && m_addr == idr_idx(c) && !h_wr[c] && !m_wr) |=> !h_str[c*DW + IBF_B]);
    // R6
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wr && m_addr == odr_idx(c)) |=> h_str[c*DW + OBF_B]);
    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(chan_irq[c])) |-> ($past(arm[c]) && $past(h_wr[c])));
  end

  // R9
  agg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_out == |$past({aux_irq, chan_irq})));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && !is_mapped(m_addr)) |-> (m_rdata == '0));
endmodule

bind kcs_mbox kcs_mbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
  .m_rdata(m_rdata), .h_wr(h_wr), .h_rd(h_rd), .h_str(h_str),
  .aux_irq(aux_irq), .chan_irq(chan_irq), .irq_out(irq_out), .arm(arm)
);

// File: tb/kcs_mbox_test.sv
module kcs_mbox_test;
  localparam logic [31:0] STRAP = 32'hA5C3_0F1E;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [9:0]   m_addr = '0;
  logic         m_wr = 1'b0, m_rd = 1'b0;
  logic [31:0]  m_wdata = '0;
  logic [31:0]  m_rdata;
  logic [3:0]   h_wr = '0, h_rd = '0;
  logic [127:0] h_wdata = '0;
  logic [127:0] h_odr, h_str;
  logic         aux_irq = 1'b0;
  logic [3:0]   chan_irq;
  logic         irq_out;

  kcs_mbox #(.STRAP7(STRAP)) uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int unsigned ctl_m [10];
  int unsigned idr_m [4], odr_m [4], str_m [4];
  bit irq_m [4];
  bit [4:0] pend_m;

  function automatic int ctl_slot(input int unsigned b);
    int unsigned offs [10] = '{'h0, 'h4, 'h8, 'hC, 'h10, 'h80, 'h84, 'h88, 'h8C, 'h100};
    for (int k = 0; k < 10; k++) if (offs[k] == b) return k;
    return -1;
  endfunction
  function automatic int unsigned a_idr(input int c);
    return (c == 3) ? 'h114 : 'h24 + 4 * c;
  endfunction
  function automatic int unsigned a_odr(input int c);
    return (c == 3) ? 'h118 : 'h30 + 4 * c;
  endfunction
  function automatic int unsigned a_str(input int c);
    return (c == 3) ? 'h11C : 'h3C + 4 * c;
  endfunction

  function automatic bit armed(input int c);
    case (c)
      0: return ctl_m[0][5] && ctl_m[2][1];
      1: return ctl_m[0][6] && ctl_m[2][2];
      2: return ctl_m[0][7] && ctl_m[4][2] && ctl_m[2][3];
      default: return ctl_m[9][0] && ctl_m[9][1];
    endcase
  endfunction

  function automatic int unsigned model_rd(input int unsigned b);
    int k;
    k = ctl_slot(b);
    if (k >= 0) return ctl_m[k];
    for (int c = 0; c < 4; c++) begin
      if (b == a_idr(c)) return idr_m[c];
      if (b == a_odr(c)) return odr_m[c];
      if (b == a_str(c)) return str_m[c];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (ctl_m[k]) ctl_m[k] = 0;
      ctl_m[7] = STRAP;
      for (int c = 0; c < 4; c++) begin
        idr_m[c] = 0; odr_m[c] = 0; str_m[c] = 0; irq_m[c] = 0;
      end
      pend_m = '0;
    end else begin
      int unsigned b, s;
      bit nirq [4];
      b = {20'd0, m_addr, 2'b00};
      pend_m = {aux_irq, irq_m[3], irq_m[2], irq_m[1], irq_m[0]};
      for (int c = 0; c < 4; c++) begin
        s = (m_wr && b == a_str(c)) ? m_wdata : str_m[c];
        if (m_rd && b == a_idr(c)) s[1] = 0;
        if (h_rd[c]) s[0] = 0;
        if (h_wr[c]) s[1] = 1;
        if (m_wr && b == a_odr(c)) s[0] = 1;
        nirq[c] = irq_m[c];
        if (m_rd && b == a_idr(c) && str_m[c][1]) nirq[c] = 0;
        if (h_wr[c] && armed(c)) nirq[c] = 1;
        str_m[c] = s;
        if (h_wr[c]) idr_m[c] = h_wdata[c*32 +: 32];
        else if (m_wr && b == a_idr(c)) idr_m[c] = m_wdata;
        if (m_wr && b == a_odr(c)) odr_m[c] = m_wdata;
      end
      for (int c = 0; c < 4; c++) irq_m[c] = nirq[c];
      if (m_wr && ctl_slot(b) >= 0) ctl_m[ctl_slot(b)] = m_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, after inputs settle, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 m_rdata", m_rdata, model_rd({20'd0, m_addr, 2'b00}));
      for (int c = 0; c < 4; c++) begin
        chk("R6 h_odr", h_odr[c*32 +: 32], odr_m[c]);
        chk("R4 h_str", h_str[c*32 +: 32], str_m[c]);
        chk("R3 chan_irq", {31'd0, chan_irq[c]}, {31'd0, irq_m[c]});
      end
      chk("R9 irq_out", {31'd0, irq_out}, {31'd0, |pend_m});
    end
  end

  task automatic idle();
    m_wr = 0; m_rd = 0; h_wr = '0; h_rd = '0;
  endtask
  task automatic mwr(input int unsigned b, input logic [31:0] d);
    @(negedge clk); idle(); m_addr = b[11:2]; m_wr = 1; m_wdata = d;
    @(negedge clk); idle();
  endtask
  task automatic mrd(input int unsigned b, output logic [31:0] d);
    @(negedge clk); idle(); m_addr = b[11:2]; m_rd = 1; #1 d = m_rdata;
    @(negedge clk); idle();
  endtask
  task automatic hwr(input int c, input logic [31:0] d);
    @(negedge clk); idle(); h_wr[c] = 1; h_wdata[c*32 +: 32] = d;
    @(negedge clk); idle();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    mrd('h88, d); chk("R1 strap", d, STRAP);
    mrd('h00, d); chk("R1 ctl0", d, 0);
    mrd('h11C, d); chk("R1 str4", d, 0);
    chk("R1 irq", {28'd0, chan_irq}, 0);
    // arm all channels
    mwr('h00, 32'h0000_00E0);
    mwr('h08, 32'h0000_000E);
    mwr('h10, 32'h0000_0004);
    mwr('h100, 32'h0000_0003);
    for (int c = 0; c < 4; c++) begin
      hwr(c, 32'h40 + c);
      chk("R4 ibf", {31'd0, h_str[c*32 + 1]}, 1);
      chk("R4 irq", {31'd0, chan_irq[c]}, 1);
      mrd(a_idr(c), d); chk("R4 data", d, 32'h40 + c);
      chk("R5 ibf clr", {31'd0, h_str[c*32 + 1]}, 0);
      chk("R5 irq low", {31'd0, chan_irq[c]}, 0);
    end
    // R3: channel 3 loses its second enable
    mwr('h10, 0);
    hwr(2, 32'h77);
    chk("R3 ch3 gated", {31'd0, chan_irq[2]}, 0);
    // R6 output path
    mwr(a_odr(1), 32'hBEEF);
    chk("R6 obf", {31'd0, h_str[32]}, 1);
    @(negedge clk); h_rd[1] = 1; #1 chk("R6 host data", h_odr[63:32], 32'hBEEF);
    @(negedge clk); idle();
    chk("R6 obf clr", {31'd0, h_str[32]}, 0);
    // R7 collisions
    @(negedge clk); m_addr = a_idr(0) >> 2; m_rd = 1; h_wr[0] = 1; h_wdata[31:0] = 32'h99;
    @(negedge clk); idle();
    chk("R7 ibf wins", {31'd0, h_str[1]}, 1);
    @(negedge clk); m_addr = a_odr(3) >> 2; m_wr = 1; m_wdata = 32'h55; h_rd[3] = 1;
    @(negedge clk); idle();
    chk("R7 obf wins", {31'd0, h_str[96]}, 1);
    // R8 status write, bit 3
    mwr(a_str(2), 32'h0000_0008);
    chk("R8 str", h_str[95:64], 32'h8);
    // R5 read with flag clear keeps interrupt
    mwr(a_str(0), 0);
    mrd(a_idr(0), d);
    chk("R5 keep irq", {31'd0, chan_irq[0]}, 1);
    // R9 aux source
    @(negedge clk); aux_irq = 1;
    @(negedge clk); chk("R9 aux", {31'd0, irq_out}, 1);
    aux_irq = 0;
    // R10 unmapped
    mwr('h200, 32'hFFFF_FFFF); mrd('h200, d); chk("R10 hole", d, 0);
    mwr('h14, 32'h1234); mrd('h14, d); chk("R10 gap", d, 0);
    mrd('hFFC, d); chk("R10 top", d, 0);
    // random traffic, compared each cycle by the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned pick;
      @(negedge clk);
      idle();
      pick = $urandom_range(0, 15);
      case (pick % 4)
        0: pick = a_idr($urandom_range(0, 3));
        1: pick = a_odr($urandom_range(0, 3));
        2: pick = a_str($urandom_range(0, 3));
        default: pick = ($urandom_range(0, 3) == 0) ? 'h100 : 4 * $urandom_range(0, 5);
      endcase
      m_addr = pick[11:2];
      m_wdata = $urandom;
      m_wr = ($urandom_range(0, 3) == 0);
      m_rd = !m_wr && ($urandom_range(0, 1) == 0);
      h_wr = 4'($urandom);
      h_rd = 4'($urandom);
      h_wdata = {$urandom, $urandom, $urandom, $urandom};
      aux_irq = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk); idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule